// File: doc/BRIEF.md
# Serial Master Frame Sequencer

This block is a synchronous serial master. It takes fixed-width words from a valid/ready parallel port and shifts each one out on a transmit line, most significant bit first. While it does so, it samples a receive line into a word of the same width. It drives the serial clock, which idles low, and an active-low frame select. It also drives an active-low output enable, so that the transmit pad can be released between frames.

Every event in a frame falls on a boundary of a half serial-clock period. That half period is a programmable number of system clocks. After the last bit of a word has been sampled, the sequencer takes another word straight away if one is offered at that moment. In that case it raises frame select for one half period and then starts the next word. If no word is offered, it ends the frame and returns to idle. A `phase_sel` input chooses which clock edge samples and which edge drives.

The control is a five-state machine:
- `ST_IDLE`: waiting for a word.
- `ST_LEAD`: frame select low, lines quiet, for one half period.
- `ST_SHIFT`: the 2·WIDTH half-period steps in which data moves.
- `ST_TAIL`: the closing half period.
- `ST_GAP`: frame select high between words.

The transitions are:
- IDLE→LEAD when a word is accepted.
- LEAD→SHIFT when the half period expires.
- SHIFT→SHIFT on each step.
- SHIFT→TAIL after the last step.
- TAIL→GAP when a follow-on word is held.
- TAIL→IDLE when no follow-on word is held.
- GAP→LEAD when the half period expires.

Top module: `spi_master_seq`

## Requirements
- R1: Out of reset and while idle, the outputs are `fs_n`=1, `oe_n`=1, `sclk`=0, `txd`=0 and `in_ready`=1.
- R2: A word is accepted at a clock edge where `in_valid` and `in_ready` are both 1. `fs_n` is 0 right after that edge. For H system clocks (one half period), `txd` and `sclk` stay 0. At that point, bit WIDTH-1 of the word appears on `txd`.
- R3: With `phase_sel`=1, `sclk` first rises one half period after the first bit appears. `txd` changes only together with a falling `sclk`, and `rxd` is sampled at each rising edge. With `phase_sel`=0, the first bit appears together with the first rising edge. `txd` then changes with each rising edge, and `rxd` is sampled at each falling edge.
- R4: Transmit bits go out most significant first. Bit j (counted from the MSB) is held on `txd` for two half periods.
- R5: The half period H equals `half_div` system clocks. A `half_div` of 0 behaves as 1.
- R6: When no further word follows, `fs_n` returns to 1 exactly 2·H system clocks after the last sampling edge. The block is then idle.
- R7: If `in_valid` is 1 in the single cycle that `in_ready` is 1 after the last sampling edge, that word is taken. `fs_n` then rises at the same point as in R6, stays 1 for exactly H clocks, and the next word starts as in R2.
- R8: During a frame, `in_ready` is 1 only in the first system clock after the last sampling edge. It is 1 again from the moment `fs_n` returns high at the end of a frame.
- R9: `rx_valid` is a single-cycle pulse in the first system clock after the last sampling edge. In that cycle `rx_data` holds the WIDTH sampled bits, the first sampled bit in the MSB.
- R10: `oe_n` is 0 exactly while `fs_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | Half serial-clock period in system clocks (0 acts as 1) |
| phase_sel | input | 1 | 1: sample on rising and drive on falling edge; 0: drive on rising and sample on falling edge |
| in_valid | input | 1 | Transmit word offered |
| in_ready | output | 1 | Transmit word can be taken this cycle |
| in_data | input | WIDTH | Transmit word |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | WIDTH | Received word |
| sclk | output | 1 | Serial clock, idles low |
| fs_n | output | 1 | Frame select, active low |
| oe_n | output | 1 | Transmit output enable, active low |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The bench sends every 4-bit word as a single-word frame, under both phase settings and with a divider setting of 0, 1, 2 and 3. It compares each output in every system clock against a timeline computed from the half-period arithmetic.

The full word sweep shows whether bit order and bit selection are correct. The divider settings show whether step lengths are counted correctly, and whether the zero case behaves as one. The two phase settings show whether sampling and driving sit on the correct edges.

Bursts of two and three words then hold `in_valid` high through the continuation window. These tell a proper gap between words apart from a frame select that stays low across a word boundary or returns to idle too early.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } seq_state_t;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // zero is treated as a one-clock half period
    assign limit = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tick  = run && (cnt_q == limit - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             last,
    input  logic             rxd,
    output logic             rx_valid,
    output logic [WIDTH-1:0] rx_data
);
    logic [WIDTH-2:0] part_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q   <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample) begin
                part_q <= {part_q[WIDTH-3:0], rxd};
                if (last) begin
                    rx_data  <= {part_q, rxd};
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_master_seq.sv
module spi_master_seq
    import spi_seq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             phase_sel,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             rx_valid,
    output logic [WIDTH-1:0] rx_data,
    output logic             sclk,
    output logic             fs_n,
    output logic             oe_n,
    output logic             txd,
    input  logic             rxd
);
    localparam int STEPS  = 2 * WIDTH;
    localparam int STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [WIDTH-1:0]  tx_sr_q;
    logic              cont_q;
    logic              tick;
    logic              hand;
    logic              enter_step;
    logic              enter_last;
    logic              drive_bit;
    logic              sample_bit;
    logic              frame_d;

    assign hand = in_valid && in_ready;

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .half_div (half_div),
        .tick     (tick)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE:  if (hand) state_d = ST_LEAD;
            ST_LEAD:  if (tick) begin
                          state_d = ST_SHIFT;
                          step_d  = '0;
                      end
            ST_SHIFT: if (tick) begin
                          if (step_q == LAST_STEP) state_d = ST_TAIL;
                          else                     step_d  = step_q + STEP_W'(1);
                      end
            ST_TAIL:  if (tick) state_d = cont_q ? ST_GAP : ST_IDLE;
            ST_GAP:   if (tick) state_d = ST_LEAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign enter_step = tick && ((state_q == ST_LEAD) ||
                                 (state_q == ST_SHIFT && step_q != LAST_STEP));
    assign enter_last = enter_step && (step_d == LAST_STEP);
    assign drive_bit  = enter_step && !step_d[0];
    assign sample_bit = enter_step &&  step_d[0];
    assign frame_d    = (state_d == ST_LEAD) || (state_d == ST_SHIFT) ||
                        (state_d == ST_TAIL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_ready <= 1'b1;
            fs_n     <= 1'b1;
            oe_n     <= 1'b1;
            sclk     <= 1'b0;
            txd      <= 1'b0;
            tx_sr_q  <= '0;
            cont_q   <= 1'b0;
        end else begin
            in_ready <= (state_d == ST_IDLE) || enter_last;
            fs_n     <= !frame_d;
            oe_n     <= !frame_d;

            if (hand && state_q == ST_SHIFT)
                cont_q <= 1'b1;
            else if (state_q == ST_TAIL && tick)
                cont_q <= 1'b0;

            if (hand)
                tx_sr_q <= in_data;
            else if (drive_bit)
                tx_sr_q <= {tx_sr_q[WIDTH-2:0], 1'b0};

            if (drive_bit)
                txd <= tx_sr_q[WIDTH-1];
            else if (state_d != ST_SHIFT)
                txd <= 1'b0;

            if (enter_step)
                sclk <= step_d[0] ^ !phase_sel;
            else if (state_d != ST_SHIFT)
                sclk <= 1'b0;
        end
    end

    spi_rx_shift #(.WIDTH(WIDTH)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample_bit),
        .last     (enter_last),
        .rxd      (rxd),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );
endmodule

// File: rtl/spi_master_seq_chk.sv
module spi_master_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic fs_n,
    input logic oe_n,
    input logic sclk,
    input logic txd,
    input logic in_valid,
    input logic in_ready,
    input logic rx_valid
);
    // R1: quiet lines whenever frame select is high
    a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        fs_n |-> (!sclk && !txd));

    // R2: the frame opens with clock and data low
    a_r2_lead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fs_n) |-> (!sclk && !txd));

    // R3 / R10: serial clock only rises inside an enabled frame
    a_r3_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (!fs_n && !oe_n));

    // R8: ready drops right after a word is taken
    a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R9: receive strobe lasts one cycle
    a_r9_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind spi_master_seq spi_master_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_n     (fs_n),
    .oe_n     (oe_n),
    .sclk     (sclk),
    .txd      (txd),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .rx_valid (rx_valid)
);

// File: tb/spi_master_seq_test.sv
module spi_master_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] half_div = '0;
    logic          phase_sel = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic          rx_valid;
    logic [W-1:0]  rx_data;
    logic          sclk, fs_n, oe_n, txd;
    logic          rxd = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [W-1:0] wq [4];
    logic [W-1:0] rq [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_master_seq #(.WIDTH(W), .DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .phase_sel(phase_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .fs_n(fs_n),
        .oe_n(oe_n), .txd(txd), .rxd(rxd)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_burst(input int n, input int hd, input bit ph);
        int h, p, f, u, step;
        bit infr;
        h = (hd == 0) ? 1 : hd;
        p = h * (2 * W + 3);
        @(negedge clk);
        half_div  = DW'(hd);
        phase_sel = ph;
        in_data   = wq[0];
        in_valid  = 1'b1;
        rxd       = rq[0][W-1];
        chk("R8", "ready before frame", int'(in_ready), 1);
        @(posedge clk);
        for (int t = 0; t < n * p; t++) begin
            @(negedge clk);
            f = t / p;
            u = t % p;
            step = (u >= h && u < (2 * W + 1) * h) ? (u / h - 1) : -1;
            infr = (u < (2 * W + 2) * h);
            chk((u < h) ? "R2" : ((!infr && f < n - 1) ? "R7" : "R6"),
                "fs_n", int'(fs_n), infr ? 0 : 1);
            chk("R10", "oe_n", int'(oe_n), infr ? 0 : 1);
            chk((hd == 0) ? "R5" : "R3", "sclk", int'(sclk),
                (step >= 0) ? ((step % 2) ^ (ph ? 0 : 1)) : 0);
            chk((step == 0) ? "R2" : "R4", "txd", int'(txd),
                (step >= 0) ? int'(wq[f][W - 1 - step / 2]) : 0);
            chk((f < n - 1 && u == 2 * W * h) ? "R7" : "R8", "in_ready", int'(in_ready),
                ((u == 2 * W * h) || (f == n - 1 && !infr)) ? 1 : 0);
            chk("R9", "rx_valid", int'(rx_valid), (u == 2 * W * h) ? 1 : 0);
            if (u == 2 * W * h)
                chk("R9", "rx_data", int'(rx_data), int'(rq[f]));
            if (u == 0) begin
                in_valid = (f + 1 < n);
                if (f + 1 < n) in_data = wq[f + 1];
            end
            rxd = rq[f][W - 1 - ((step >= 0) ? step / 2 : 0)];
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "fs_n in reset", int'(fs_n), 1);
        chk("R1", "sclk in reset", int'(sclk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "fs_n idle", int'(fs_n), 1);
        chk("R1", "oe_n idle", int'(oe_n), 1);
        chk("R1", "sclk idle", int'(sclk), 0);
        chk("R1", "txd idle", int'(txd), 0);
        chk("R1", "in_ready idle", int'(in_ready), 1);

        for (int ph = 0; ph < 2; ph++)
            for (int hd = 0; hd < 4; hd++)
                for (int w = 0; w < (1 << W); w++) begin
                    wq[0] = W'(w);
                    rq[0] = W'(w * 5 + 3);
                    run_burst(1, hd, ph[0]);
                end

        for (int ph = 0; ph < 2; ph++)
            for (int hd = 0; hd < 4; hd++)
                for (int n = 2; n < 4; n++) begin
                    for (int i = 0; i < 4; i++) begin
                        wq[i] = W'(hd * 7 + i * 3 + ph + n);
                        rq[i] = ~wq[i] ^ W'(i);
                    end
                    run_burst(n, hd, ph[0]);
                end

        repeat (4) @(negedge clk);
        chk("R1", "fs_n idle at end", int'(fs_n), 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule